// File: doc/BRIEF.md
# Prioritized DMA and Interrupt Bus Arbiter

This block decides which unit drives a shared bus that has a single master at a time. The processor owns the bus whenever no other unit holds it. Peripherals ask for the bus in two ways. A DMA-class request line asks for a direct memory transfer. An interrupt-class request line asks to interrupt the program, and each of these lines sits at one of four priority levels, 4 to 7. Every request input passes through a two-stage synchronizer, so a request may change at any time relative to the processor's windows.

The processor marks the moments when ownership may change. A data-window strobe is raised just before and just after each bus data cycle. A wait/trap-window strobe is raised at chosen points inside its WAIT and TRAP sequences. An instruction-end strobe is raised when the current instruction completes. The processor also supplies its current priority. DMA-class requests can be granted only at data or wait/trap windows. Interrupt-class requests can be granted only at instruction end, and only when their level is strictly above the processor priority. If both classes qualify in the same cycle, the DMA request wins.

A grant stays on until the master pulses release. Ownership then returns to the processor. A unit that took the bus through an interrupt request may use that tenure for its own transfers, and the arbiter does not take the bus back from it.

The controller has three states. In `ST_CPU` the processor owns the bus. In `ST_DMA` a DMA line holds it. In `ST_IRQ` an interrupt level holds it. The transitions are:
- `ST_CPU`→`ST_DMA`: a data or wait/trap window arrives with a synchronized DMA request present.
- `ST_CPU`→`ST_IRQ`: an instruction-end window arrives, no DMA grant is taken in that cycle, and an eligible interrupt level is present.
- `ST_DMA`→`ST_CPU` and `ST_IRQ`→`ST_CPU`: the master pulses release.

Top module: `bus_arbiter`

## Requirements
- R1: While reset is held, and after it is released with no requests present, `cpu_owns` is 1 and every bit of `dma_gnt` and `irq_gnt` is 0.
- R2: A request input passes through two flip-flops before it is used. To count at a window edge, a request must already have been high at the two rising edges before that edge. A request first seen only one edge before the window edge is not granted there.
- R3: A synchronized DMA request that is present at a rising edge where `win_data` is 1 produces a grant. `dma_gnt[i]` (bit i = DMA line i) is high from that edge on, and `cpu_owns` falls at the same edge.
- R4: `win_wt` gives DMA requests the same grant opportunity that `win_data` does.
- R5: An interrupt-class request is granted only at an edge where `win_instr_end` is 1. A DMA request is never granted at `win_instr_end` alone, and an interrupt request is never granted at `win_data` or `win_wt` alone.
- R6: `irq_req[i]` stands for priority level 4+i. It is granted only when 4+i is strictly greater than `cpu_pri`. A level equal to `cpu_pri` or below it is not granted.
- R7: If a DMA grant and an interrupt grant would both be possible at the same edge, the DMA request is granted.
- R8: Among DMA lines, the lowest index wins. Among eligible interrupt lines, the highest level wins.
- R9: At most one bit of `dma_gnt` and `irq_gnt` combined is high at any time. `cpu_owns` is 1 exactly when none of them is high.
- R10: A grant stays unchanged, whatever the new requests or windows, until `mst_release` is 1 at a rising edge. From that edge on, all grants are 0 and `cpu_owns` is 1.
- R11: A request that is withdrawn before its eligible window arrives is not granted at that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_req | input | N_DMA | DMA-class request lines, any timing |
| irq_req | input | N_LVL | Interrupt request lines; bit i is level LVL_BASE+i |
| cpu_pri | input | PRI_W | Current processor priority |
| win_data | input | 1 | Window just before or just after a data cycle |
| win_wt | input | 1 | Grant point inside a WAIT or TRAP sequence |
| win_instr_end | input | 1 | Current instruction completes |
| mst_release | input | 1 | Current master gives the bus up |
| dma_gnt | output | N_DMA | One-hot DMA grant |
| irq_gnt | output | N_LVL | One-hot interrupt grant |
| cpu_owns | output | 1 | Processor is bus master |

## Verification
A request reaches the decision logic two rising edges after it is driven. A grant appears at the edge where the window is sampled, so it is visible one edge after the window strobe was driven. Release takes effect at the next edge. The bench drives inputs and samples outputs on falling edges. It holds each request for two edges before it raises a window, and it reads the result half a cycle after the deciding edge. A behavioural model in the bench keeps the same two-edge delay in its own history variables and is compared on every falling edge. Targeted checks also look for fixed expected patterns after each scenario.

// File: rtl/arb_pkg.sv
`timescale 1ns/1ps
package arb_pkg;
    typedef enum logic [1:0] {
        ST_CPU = 2'd0,
        ST_DMA = 2'd1,
        ST_IRQ = 2'd2
    } own_state_t;
endpackage

// File: rtl/arb_sync.sv
`timescale 1ns/1ps
// Two-stage synchronizer, one chain per request bit
module arb_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1[b] <= 1'b0;
                stage2[b] <= 1'b0;
            end else begin
                stage1[b] <= async_in[b];
                stage2[b] <= stage1[b];
            end
        end
    end

    assign sync_out = stage2;
endmodule

// File: rtl/arb_pick.sv
`timescale 1ns/1ps
// Fixed-priority picker; HIGH_FIRST selects which end wins
module arb_pick #(
    parameter int W          = 4,
    parameter bit HIGH_FIRST = 1'b0,
    localparam int IW        = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  cand,
    output logic          found,
    output logic [IW-1:0] idx
);
    if (HIGH_FIRST) begin : g_high
        always_comb begin
            found = 1'b0;
            idx   = '0;
            for (int i = 0; i < W; i++) begin
                if (cand[i]) begin
                    found = 1'b1;
                    idx   = IW'(i);
                end
            end
        end
    end else begin : g_low
        always_comb begin
            found = 1'b0;
            idx   = '0;
            for (int i = W - 1; i >= 0; i--) begin
                if (cand[i]) begin
                    found = 1'b1;
                    idx   = IW'(i);
                end
            end
        end
    end
endmodule

// File: rtl/bus_arbiter.sv
`timescale 1ns/1ps
module bus_arbiter
    import arb_pkg::*;
#(
    parameter int N_DMA    = 4,
    parameter int N_LVL    = 4,
    parameter int LVL_BASE = 4,
    parameter int PRI_W    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_DMA-1:0] dma_req,
    input  logic [N_LVL-1:0] irq_req,
    input  logic [PRI_W-1:0] cpu_pri,
    input  logic             win_data,
    input  logic             win_wt,
    input  logic             win_instr_end,
    input  logic             mst_release,
    output logic [N_DMA-1:0] dma_gnt,
    output logic [N_LVL-1:0] irq_gnt,
    output logic             cpu_owns
);
    localparam int DIW = (N_DMA > 1) ? $clog2(N_DMA) : 1;
    localparam int LIW = (N_LVL > 1) ? $clog2(N_LVL) : 1;
    localparam int HIW = (DIW > LIW) ? DIW : LIW;

    logic [N_DMA-1:0] dma_s;
    logic [N_LVL-1:0] irq_s;
    logic [N_LVL-1:0] irq_elig;
    logic             dma_any;
    logic             irq_any;
    logic [DIW-1:0]   dma_idx;
    logic [LIW-1:0]   irq_idx;

    own_state_t       state_q;
    own_state_t       state_d;
    logic [HIW-1:0]   idx_q;
    logic [HIW-1:0]   idx_d;

    arb_sync #(.W(N_DMA)) u_sync_dma (
        .clk(clk), .rst_n(rst_n), .async_in(dma_req), .sync_out(dma_s)
    );

    arb_sync #(.W(N_LVL)) u_sync_irq (
        .clk(clk), .rst_n(rst_n), .async_in(irq_req), .sync_out(irq_s)
    );

    // A level is eligible only above the processor priority
    for (genvar l = 0; l < N_LVL; l++) begin : g_elig
        assign irq_elig[l] = irq_s[l] && ((LVL_BASE + l) > int'(cpu_pri));
    end

    arb_pick #(.W(N_DMA), .HIGH_FIRST(1'b0)) u_pick_dma (
        .cand(dma_s), .found(dma_any), .idx(dma_idx)
    );

    arb_pick #(.W(N_LVL), .HIGH_FIRST(1'b1)) u_pick_irq (
        .cand(irq_elig), .found(irq_any), .idx(irq_idx)
    );

    // Next-state decision
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        unique case (state_q)
            ST_CPU: begin
                if ((win_data || win_wt) && dma_any) begin
                    state_d = ST_DMA;
                    idx_d   = HIW'(dma_idx);
                end else if (win_instr_end && irq_any) begin
                    state_d = ST_IRQ;
                    idx_d   = HIW'(irq_idx);
                end
            end
            ST_DMA, ST_IRQ: begin
                if (mst_release) begin
                    state_d = ST_CPU;
                end
            end
            default: begin
                state_d = ST_CPU;
                idx_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CPU;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    // Output decode
    always_comb begin
        dma_gnt  = '0;
        irq_gnt  = '0;
        cpu_owns = 1'b0;
        unique case (state_q)
            ST_CPU: cpu_owns = 1'b1;
            ST_DMA: dma_gnt  = {{(N_DMA-1){1'b0}}, 1'b1} << idx_q;
            ST_IRQ: irq_gnt  = {{(N_LVL-1){1'b0}}, 1'b1} << idx_q;
            default: cpu_owns = 1'b1;
        endcase
    end
endmodule

// File: rtl/arb_chk.sv
`timescale 1ns/1ps
module arb_chk #(
    parameter int N_DMA    = 4,
    parameter int N_LVL    = 4,
    parameter int LVL_BASE = 4,
    parameter int PRI_W    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic [PRI_W-1:0] cpu_pri,
    input logic             win_data,
    input logic             win_wt,
    input logic             win_instr_end,
    input logic             mst_release,
    input logic [N_DMA-1:0] dma_gnt,
    input logic [N_LVL-1:0] irq_gnt,
    input logic             cpu_owns
);
    // R9
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dma_gnt, irq_gnt}));

    // R9
    owner_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_owns == ($countones({dma_gnt, irq_gnt}) == 0));

    // R10
    hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_owns && !mst_release) |=> $stable({dma_gnt, irq_gnt}));

    // R10
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_owns && mst_release) |=> cpu_owns);

    // R3
    dma_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|dma_gnt) |-> $past(win_data || win_wt));

    // R5
    irq_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|irq_gnt) |-> $past(win_instr_end));

    for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
        // R6
        irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_gnt[g]) |-> (int'($past(cpu_pri)) < (LVL_BASE + g)));
    end
endmodule

bind bus_arbiter arb_chk #(
    .N_DMA(N_DMA), .N_LVL(N_LVL), .LVL_BASE(LVL_BASE), .PRI_W(PRI_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_pri(cpu_pri), .win_data(win_data),
    .win_wt(win_wt), .win_instr_end(win_instr_end), .mst_release(mst_release),
    .dma_gnt(dma_gnt), .irq_gnt(irq_gnt), .cpu_owns(cpu_owns)
);

// File: tb/bus_arbiter_test.sv
`timescale 1ns/1ps
module bus_arbiter_test;
    localparam int ND = 4;
    localparam int NL = 4;
    localparam int LB = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [ND-1:0] dma_req = '0;
    logic [NL-1:0] irq_req = '0;
    logic [2:0]    cpu_pri = '0;
    logic          win_data = 1'b0;
    logic          win_wt = 1'b0;
    logic          win_instr_end = 1'b0;
    logic          mst_release = 1'b0;
    logic [ND-1:0] dma_gnt;
    logic [NL-1:0] irq_gnt;
    logic          cpu_owns;

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    always #2.5 clk = ~clk;

    bus_arbiter uut (
        .clk(clk), .rst_n(rst_n), .dma_req(dma_req), .irq_req(irq_req),
        .cpu_pri(cpu_pri), .win_data(win_data), .win_wt(win_wt),
        .win_instr_end(win_instr_end), .mst_release(mst_release),
        .dma_gnt(dma_gnt), .irq_gnt(irq_gnt), .cpu_owns(cpu_owns)
    );

    // Behavioural reference: owner 0 = processor, 1 = DMA, 2 = interrupt
    logic [ND-1:0] h1_d = '0, h2_d = '0;
    logic [NL-1:0] h1_i = '0, h2_i = '0;
    int m_own = 0;
    int m_idx = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_own = 0; m_idx = 0;
            h1_d = '0; h2_d = '0; h1_i = '0; h2_i = '0;
        end else begin
            if (m_own == 0) begin
                if ((win_data || win_wt) && h2_d != 0) begin
                    m_own = 1;
                    for (int k = ND - 1; k >= 0; k--) if (h2_d[k]) m_idx = k;
                end else if (win_instr_end) begin
                    for (int k = 0; k < NL; k++)
                        if (h2_i[k] && (LB + k) > int'(cpu_pri)) begin
                            m_own = 2; m_idx = k;
                        end
                end
            end else if (mst_release) begin
                m_own = 0;
            end
            h2_d = h1_d; h1_d = dma_req;
            h2_i = h1_i; h1_i = irq_req;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [ND-1:0] ed;
            logic [NL-1:0] ei;
            ed = (m_own == 1) ? ND'(1 << m_idx) : '0;
            ei = (m_own == 2) ? NL'(1 << m_idx) : '0;
            n_cmp++;
            if (dma_gnt !== ed || irq_gnt !== ei || cpu_owns !== (m_own == 0)) begin
                n_bad++;
                $display("FAIL %s model: dma=%b irq=%b own=%b expected dma=%b irq=%b own=%b",
                         cur_tag, dma_gnt, irq_gnt, cpu_owns, ed, ei, m_own == 0);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input string tag, input logic [ND-1:0] ed,
                              input logic [NL-1:0] ei, input logic eo);
        n_cmp++;
        if (dma_gnt !== ed || irq_gnt !== ei || cpu_owns !== eo) begin
            n_bad++;
            $display("FAIL %s: dma=%b irq=%b own=%b expected dma=%b irq=%b own=%b",
                     tag, dma_gnt, irq_gnt, cpu_owns, ed, ei, eo);
        end
    endtask

    task automatic pulse_data();
        win_data = 1'b1; tick(1); win_data = 1'b0;
    endtask

    task automatic pulse_end();
        win_instr_end = 1'b1; tick(1); win_instr_end = 1'b0;
    endtask

    task automatic give_back();
        mst_release = 1'b1; tick(1); mst_release = 1'b0;
    endtask

    initial begin
        tick(3);
        expect_out("R1 in reset", '0, '0, 1'b1);
        rst_n = 1'b1;
        tick(2);
        expect_out("R1 after reset", '0, '0, 1'b1);

        cur_tag = "R3";
        dma_req = 4'b0110; tick(2); pulse_data();
        expect_out("R3/R8 lowest DMA line", 4'b0010, '0, 1'b0);

        cur_tag = "R10";
        dma_req = 4'b0001; tick(2); pulse_data();
        expect_out("R10 grant held across window", 4'b0010, '0, 1'b0);
        give_back();
        expect_out("R10 release", '0, '0, 1'b1);

        cur_tag = "R4";
        win_wt = 1'b1; tick(1); win_wt = 1'b0;
        expect_out("R4 wait/trap window", 4'b0001, '0, 1'b0);
        give_back();
        dma_req = '0; tick(3);

        cur_tag = "R2";
        dma_req = 4'b0100; tick(1); pulse_data();
        expect_out("R2 one edge too early", '0, '0, 1'b1);

        cur_tag = "R11";
        dma_req = '0; tick(3); pulse_data();
        expect_out("R11 dropped request", '0, '0, 1'b1);

        cur_tag = "R5";
        irq_req = 4'b0100; tick(2);
        win_data = 1'b1; win_wt = 1'b1; tick(1); win_data = 1'b0; win_wt = 1'b0;
        expect_out("R5 interrupt at DMA window", '0, '0, 1'b1);
        irq_req = '0; dma_req = 4'b0001; tick(2); pulse_end();
        expect_out("R5 DMA at instruction end", '0, '0, 1'b1);

        cur_tag = "R7";
        irq_req = 4'b1000; tick(2);
        win_data = 1'b1; win_instr_end = 1'b1; tick(1);
        win_data = 1'b0; win_instr_end = 1'b0;
        expect_out("R7 DMA beats interrupt", 4'b0001, '0, 1'b0);
        give_back();
        dma_req = '0;

        cur_tag = "R6";
        cpu_pri = 3'd5; irq_req = 4'b0010; tick(2); pulse_end();
        expect_out("R6 equal level refused", '0, '0, 1'b1);
        irq_req = 4'b0110; tick(2); pulse_end();
        expect_out("R6 higher level granted", '0, 4'b0100, 1'b0);

        cur_tag = "R10";
        dma_req = 4'b0001; tick(2); pulse_data();
        expect_out("R10 interrupt tenure kept", '0, 4'b0100, 1'b0);
        give_back();
        expect_out("R10 release after interrupt", '0, '0, 1'b1);
        dma_req = '0; tick(3);

        cur_tag = "R8";
        cpu_pri = 3'd3; irq_req = 4'b1001; tick(2); pulse_end();
        expect_out("R8 highest level wins", '0, 4'b1000, 1'b0);
        give_back();

        cur_tag = "R6";
        cpu_pri = 3'd7; irq_req = 4'b1111; tick(2); pulse_end();
        expect_out("R6 priority 7 blocks all", '0, '0, 1'b1);
        irq_req = '0;

        cur_tag = "R9";
        tick(4);
        expect_out("R9 idle owner flag", '0, '0, 1'b1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog (all requirements): run incomplete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule